// File: doc/BRIEF.md
# Self-Timed Page Operation Sequencer

This block runs the long, self-timed operations between a paged non-volatile array and two page-sized staging buffers. A command front end, which is not part of this block, decodes a serial command. When chip select rises it presents the request as a one-cycle strobe carrying an operation code, a buffer select and a page number. The sequencer then moves a page into a buffer, compares a page with a buffer, programs a buffer into a page (with or without a preceding erase), or rewrites a page through a buffer. Each step is timed in clock cycles. The ready output is low for the whole operation.

The two buffers live inside the block. A host byte port lets the command front end fill and read them at any time, which is how buffer-only commands keep working during array activity. Writes to the buffer that the running operation owns are dropped. The array sits outside the block and is reached through a byte-wide port with a combinational read. A write-protect input shields the low pages from any operation that programs. A second array request during a running operation is refused and flagged, not queued.

Top module: `page_op_sequencer`

## Requirements
- R1: After reset, ready is 1, both reject flags are 0, the compare-mismatch status is 0 and no array write is issued.
- R2: Operation code 0 (load) copies every byte of the requested page into the selected buffer and leaves the page unchanged; ready is low for PAGE_BYTES cycles.
- R3: Operation code 1 (check) compares every byte of the page with the selected buffer. The status becomes 0 on a full match and 1 if any bit differs. It holds that value until the next check completes. Ready is low for PAGE_BYTES cycles.
- R4: Operation code 2 (erase-and-write) first writes 0xFF to all PAGE_BYTES bytes of the page, then writes the buffer into it. That is 2*PAGE_BYTES array writes in total, and ready is low for 2*PAGE_BYTES+ERASE_SETTLE+PROG_SETTLE cycles.
- R5: Operation code 3 (write only) writes the buffer into the page with PAGE_BYTES array writes and no erase pass; ready is low for PAGE_BYTES+PROG_SETTLE cycles.
- R6: Operation code 4 (refresh) loads the page into the selected buffer, then erases the page and writes that buffer back. The page keeps its contents, the buffer ends equal to it, and ready is low for 3*PAGE_BYTES+ERASE_SETTLE+PROG_SETTLE cycles.
- R7: A request with a known code that arrives while ready is low, including in the last busy cycle, is refused. rejectBusy is 1 for exactly the next cycle, and the running operation keeps its duration and result.
- R8: While wpN is 0, a request with code 2, 3 or 4 to a page below PROT_PAGES does not start. rejectProtect is 1 for one cycle, ready stays 1 and the page is unchanged. Codes 0 and 1 to such a page still run, and with wpN at 1 programming that page works.
- R9: Ready falls in the cycle after the clock edge that accepts a request and stays low for exactly the operation duration.
- R10: During an operation, host writes to the buffer not selected by the operation take effect, even in cycles where the operation writes or reads the other buffer. Host writes to the selected buffer are ignored.
- R11: A low rstN ends any operation at once: ready goes to 1 and the status returns to 0. The block stays idle while rstN is low and accepts new requests after release.
- R12: Operation codes 5, 6 and 7 are ignored: ready stays 1 and neither reject flag is raised.
- R13: reqBuf selects buffer 0 or buffer 1 as the source or destination of the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset and abort |
| reqValid | input | 1 | One-cycle request strobe at chip-select release |
| reqOp | input | 3 | Operation code (0 load, 1 check, 2 erase-and-write, 3 write only, 4 refresh) |
| reqBuf | input | 1 | Buffer select |
| reqPage | input | PAGE_W | Target page |
| wpN | input | 1 | Write protect, active low |
| hostWe | input | 1 | Host buffer write enable |
| hostSel | input | 1 | Host buffer select |
| hostAddr | input | BYTE_W | Host byte address in the buffer |
| hostWdata | input | 8 | Host write byte |
| hostRdata | output | 8 | Host read byte (combinational) |
| arrPage | output | PAGE_W | Array page address |
| arrByte | output | BYTE_W | Array byte address |
| arrWe | output | 1 | Array byte write enable |
| arrWdata | output | 8 | Array write byte |
| arrRdata | input | 8 | Array read byte for the current address |
| ready | output | 1 | 1 when idle, 0 during an operation |
| cmpMismatch | output | 1 | Result of the last completed check |
| rejectBusy | output | 1 | Pulse: request refused because busy |
| rejectProtect | output | 1 | Pulse: request refused by write protect |

## Verification
Two functions can fall in the same clock edge. The first pair is a host write to one buffer while the operation is loading into, or reading from, the other buffer. The second pair is a new request arriving in the very cycle an operation finishes. The bench provokes the first case by issuing host writes to both buffers while a load and a write-only operation run. It judges the outcome afterwards by reading both buffers back through the host port and comparing the programmed page. The bench provokes the second case by driving a request exactly in the last busy cycle. It expects rejectBusy in the following cycle, with ready high and no new operation started.

// File: rtl/page_op_pkg.sv
`timescale 1ns/1ps
package page_op_pkg;

  typedef enum logic [2:0] {
    OP_LOAD        = 3'd0,
    OP_CHECK       = 3'd1,
    OP_ERASE_WRITE = 3'd2,
    OP_WRITE       = 3'd3,
    OP_REFRESH     = 3'd4
  } pgOp_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_FETCH, PH_CHECK, PH_CLEAR, PH_CLEAR_WAIT, PH_STORE, PH_STORE_WAIT
  } phase_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic active;
    logic fetch;
    logic check;
    logic checkFirst;
    logic checkLast;
    logic clear;
    logic store;
    logic bufSel;
  } strobe_t;

  function automatic logic isKnownOp(input logic [2:0] op);
    return op <= 3'd4;
  endfunction

  function automatic logic isWriteOp(input logic [2:0] op);
    return (op == OP_ERASE_WRITE) || (op == OP_WRITE) || (op == OP_REFRESH);
  endfunction

endpackage

// File: rtl/page_op_ctrl.sv
`timescale 1ns/1ps
module page_op_ctrl
  import page_op_pkg::*;
#(
  parameter int PAGE_W       = 12,
  parameter int PAGE_BYTES   = 264,
  parameter int ERASE_SETTLE = 40,
  parameter int PROG_SETTLE  = 20,
  parameter int PROT_PAGES   = 256,
  localparam int BYTE_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic              reqBuf,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic              wpN,
  output strobe_t           stb,
  output logic [BYTE_W-1:0] byteIdx,
  output logic [PAGE_W-1:0] curPage,
  output logic              busy,
  output logic              rejectBusy,
  output logic              rejectProtect
);

  localparam int MAX_A   = (PAGE_BYTES > ERASE_SETTLE) ? PAGE_BYTES : ERASE_SETTLE;
  localparam int MAX_LEN = (MAX_A > PROG_SETTLE) ? MAX_A : PROG_SETTLE;
  localparam int CNT_W   = $clog2(MAX_LEN + 1);
  localparam logic [PAGE_W:0] PROT_LIM = (PAGE_W+1)'(PROT_PAGES);

  phase_e            phase, nextPhase, startPhase;
  logic [CNT_W-1:0]  cnt;
  logic [2:0]        opReg;
  logic              bufReg;
  logic [PAGE_W-1:0] pageReg;
  logic              lastStep;
  logic              protHit;
  int                curLen;

  always_comb begin
    case (phase)
      PH_CLEAR_WAIT: curLen = ERASE_SETTLE;
      PH_STORE_WAIT: curLen = PROG_SETTLE;
      default:       curLen = PAGE_BYTES;
    endcase
  end

  assign lastStep = (cnt == CNT_W'(curLen - 1));
  assign protHit  = isWriteOp(reqOp) && !wpN && ({1'b0, reqPage} < PROT_LIM);

  // Phase that follows the current one when its counter expires.
  always_comb begin
    case (phase)
      PH_FETCH:      nextPhase = (opReg == OP_REFRESH) ? PH_CLEAR : PH_IDLE;
      PH_CLEAR:      nextPhase = (ERASE_SETTLE > 0) ? PH_CLEAR_WAIT : PH_STORE;
      PH_CLEAR_WAIT: nextPhase = PH_STORE;
      PH_STORE:      nextPhase = (PROG_SETTLE > 0) ? PH_STORE_WAIT : PH_IDLE;
      default:       nextPhase = PH_IDLE;
    endcase
  end

  always_comb begin
    case (reqOp)
      OP_LOAD, OP_REFRESH: startPhase = PH_FETCH;
      OP_CHECK:            startPhase = PH_CHECK;
      OP_ERASE_WRITE:      startPhase = PH_CLEAR;
      default:             startPhase = PH_STORE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase         <= PH_IDLE;
      cnt           <= '0;
      opReg         <= '0;
      bufReg        <= 1'b0;
      pageReg       <= '0;
      rejectBusy    <= 1'b0;
      rejectProtect <= 1'b0;
    end else begin
      rejectBusy    <= 1'b0;
      rejectProtect <= 1'b0;
      if (phase == PH_IDLE) begin
        if (reqValid && isKnownOp(reqOp)) begin
          if (protHit) begin
            rejectProtect <= 1'b1;
          end else begin
            phase   <= startPhase;
            cnt     <= '0;
            opReg   <= reqOp;
            bufReg  <= reqBuf;
            pageReg <= reqPage;
          end
        end
      end else begin
        if (reqValid && isKnownOp(reqOp)) rejectBusy <= 1'b1;
        if (lastStep) begin
          phase <= nextPhase;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign busy    = (phase != PH_IDLE);
  assign byteIdx = cnt[BYTE_W-1:0];
  assign curPage = pageReg;

  always_comb begin
    stb            = '0;
    stb.active     = busy;
    stb.fetch      = (phase == PH_FETCH);
    stb.check      = (phase == PH_CHECK);
    stb.checkFirst = (phase == PH_CHECK) && (cnt == '0);
    stb.checkLast  = (phase == PH_CHECK) && lastStep;
    stb.clear      = (phase == PH_CLEAR);
    stb.store      = (phase == PH_STORE);
    stb.bufSel     = bufReg;
  end

  // R7: a request during an operation never replaces the running one.
  a_r7_keep_running_op: assert property (@(posedge clk) disable iff (!rstN)
    busy && reqValid |=> $stable(opReg) && $stable(pageReg));

  // R8: a protected program request never starts.
  a_r8_protect_no_start: assert property (@(posedge clk) disable iff (!rstN)
    !busy && reqValid && protHit |=> !busy && rejectProtect);

  // R12: unknown codes neither start nor flag.
  a_r12_unknown_ignored: assert property (@(posedge clk) disable iff (!rstN)
    !busy && reqValid && !isKnownOp(reqOp) |=> !busy && !rejectProtect);

endmodule

// File: rtl/page_op_datapath.sv
`timescale 1ns/1ps
module page_op_datapath
  import page_op_pkg::*;
#(
  parameter int PAGE_W     = 12,
  parameter int PAGE_BYTES = 264,
  localparam int BYTE_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [BYTE_W-1:0] byteIdx,
  input  logic [PAGE_W-1:0] curPage,
  input  logic              hostWe,
  input  logic              hostSel,
  input  logic [BYTE_W-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic [PAGE_W-1:0] arrPage,
  output logic [BYTE_W-1:0] arrByte,
  output logic              arrWe,
  output logic [7:0]        arrWdata,
  input  logic [7:0]        arrRdata,
  output logic              cmpMismatch
);

  logic [7:0] bufMem [0:1][0:PAGE_BYTES-1];
  logic [7:0] engByte;
  logic       hostBlocked;
  logic       diffNow;
  logic       cmpAcc;
  logic       accNext;

  assign engByte     = bufMem[stb.bufSel][byteIdx];
  assign hostBlocked = stb.active && (hostSel == stb.bufSel);
  assign hostRdata   = bufMem[hostSel][hostAddr];

  // Buffer storage: engine fill and host writes; they never share a buffer.
  always_ff @(posedge clk) begin
    if (stb.fetch) bufMem[stb.bufSel][byteIdx] <= arrRdata;
    if (hostWe && !hostBlocked) bufMem[hostSel][hostAddr] <= hostWdata;
  end

  // Running page comparison.
  assign diffNow = (engByte != arrRdata);
  assign accNext = stb.checkFirst ? diffNow : (cmpAcc | diffNow);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpAcc      <= 1'b0;
      cmpMismatch <= 1'b0;
    end else if (stb.check) begin
      cmpAcc <= accNext;
      if (stb.checkLast) cmpMismatch <= accNext;
    end
  end

  assign arrPage  = curPage;
  assign arrByte  = byteIdx;
  assign arrWe    = stb.clear | stb.store;
  assign arrWdata = stb.clear ? 8'hFF : engByte;

  // R3: the status moves only when a check finishes.
  a_r3_status_holds: assert property (@(posedge clk) disable iff (!rstN)
    !stb.checkLast |=> $stable(cmpMismatch));

  // R9: no array write while idle.
  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (!rstN)
    !stb.active |-> !arrWe);

  // R10: host write to the engine's buffer leaves the byte unchanged.
  a_r10_host_blocked: assert property (@(posedge clk) disable iff (!rstN)
    hostWe && stb.active && (hostSel == stb.bufSel) && !stb.fetch
    |=> bufMem[$past(hostSel)][$past(hostAddr)] == $past(bufMem[hostSel][hostAddr]));

endmodule

// File: rtl/page_op_sequencer.sv
`timescale 1ns/1ps
module page_op_sequencer
  import page_op_pkg::*;
#(
  parameter int PAGE_W       = 12,
  parameter int PAGE_BYTES   = 264,
  parameter int ERASE_SETTLE = 40,
  parameter int PROG_SETTLE  = 20,
  parameter int PROT_PAGES   = 256,
  localparam int BYTE_W      = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqOp,
  input  logic              reqBuf,
  input  logic [PAGE_W-1:0] reqPage,
  input  logic              wpN,
  input  logic              hostWe,
  input  logic              hostSel,
  input  logic [BYTE_W-1:0] hostAddr,
  input  logic [7:0]        hostWdata,
  output logic [7:0]        hostRdata,
  output logic [PAGE_W-1:0] arrPage,
  output logic [BYTE_W-1:0] arrByte,
  output logic              arrWe,
  output logic [7:0]        arrWdata,
  input  logic [7:0]        arrRdata,
  output logic              ready,
  output logic              cmpMismatch,
  output logic              rejectBusy,
  output logic              rejectProtect
);

  strobe_t           stb;
  logic [BYTE_W-1:0] byteIdx;
  logic [PAGE_W-1:0] curPage;
  logic              busy;

  page_op_ctrl #(
    .PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES), .ERASE_SETTLE(ERASE_SETTLE),
    .PROG_SETTLE(PROG_SETTLE), .PROT_PAGES(PROT_PAGES)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqBuf(reqBuf),
    .reqPage(reqPage), .wpN(wpN), .stb(stb), .byteIdx(byteIdx), .curPage(curPage),
    .busy(busy), .rejectBusy(rejectBusy), .rejectProtect(rejectProtect)
  );

  page_op_datapath #(
    .PAGE_W(PAGE_W), .PAGE_BYTES(PAGE_BYTES)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .stb(stb), .byteIdx(byteIdx), .curPage(curPage),
    .hostWe(hostWe), .hostSel(hostSel), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .arrPage(arrPage), .arrByte(arrByte), .arrWe(arrWe),
    .arrWdata(arrWdata), .arrRdata(arrRdata), .cmpMismatch(cmpMismatch)
  );

  assign ready = !busy;

endmodule

// File: tb/test_page_op_sequencer.sv
`timescale 1ns/1ps
module test_page_op_sequencer;

  localparam int PW = 12;
  localparam int PB = 264;
  localparam int ES = 40;
  localparam int PS = 20;
  localparam int PROT = 256;
  localparam int BW = $clog2(PB);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic [2:0] reqOp = '0;
  logic reqBuf = 1'b0;
  logic [PW-1:0] reqPage = '0;
  logic wpN = 1'b1;
  logic hostWe = 1'b0;
  logic hostSel = 1'b0;
  logic [BW-1:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic [PW-1:0] arrPage;
  logic [BW-1:0] arrByte;
  logic arrWe;
  logic [7:0] arrWdata;
  logic [7:0] arrRdata;
  logic ready, cmpMismatch, rejectBusy, rejectProtect;

  always #2.5 clk = ~clk;

  page_op_sequencer #(.PAGE_W(PW), .PAGE_BYTES(PB), .ERASE_SETTLE(ES),
    .PROG_SETTLE(PS), .PROT_PAGES(PROT)) i_page_op_sequencer (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp), .reqBuf(reqBuf),
    .reqPage(reqPage), .wpN(wpN), .hostWe(hostWe), .hostSel(hostSel),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .arrPage(arrPage), .arrByte(arrByte), .arrWe(arrWe), .arrWdata(arrWdata),
    .arrRdata(arrRdata), .ready(ready), .cmpMismatch(cmpMismatch),
    .rejectBusy(rejectBusy), .rejectProtect(rejectProtect));

  // Behavioural array: four page slots.
  logic [7:0] mem [0:3][0:PB-1];
  logic [7:0] expMem [0:3][0:PB-1];
  logic [7:0] expBuf [0:1][0:PB-1];
  int wrCount = 0;
  int ffCount = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic int slotOf(input logic [PW-1:0] p);
    case (p)
      12'd7:   return 0;
      12'd300: return 1;
      12'd301: return 2;
      default: return 3;
    endcase
  endfunction

  always_comb arrRdata = mem[slotOf(arrPage)][arrByte];

  always @(posedge clk) begin
    if (arrWe) begin
      mem[slotOf(arrPage)][arrByte] <= arrWdata;
      wrCount <= wrCount + 1;
      if (arrWdata == 8'hFF) ffCount <= ffCount + 1;
    end
  end

  function automatic int expDur(input int op);
    case (op)
      0, 1:    return PB;
      2:       return 2*PB + ES + PS;
      3:       return PB + PS;
      default: return 3*PB + ES + PS;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic hostWrite(input bit b, input int a, input logic [7:0] d, input bit model);
    @(negedge clk);
    hostWe = 1'b1; hostSel = b; hostAddr = BW'(a); hostWdata = d;
    @(negedge clk);
    hostWe = 1'b0;
    if (model) expBuf[b][a] = d;
  endtask

  task automatic fillBuf(input bit b);
    for (int i = 0; i < PB; i++) hostWrite(b, i, 8'($urandom), 1'b1);
  endtask

  task automatic issue(input int op, input bit b, input int page);
    @(negedge clk);
    reqValid = 1'b1; reqOp = 3'(op); reqBuf = b; reqPage = PW'(page);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitIdle(inout int len);
    while (ready == 1'b0 && len < 5000) begin
      len++;
      @(negedge clk);
    end
  endtask

  task automatic applyModel(input int op, input bit b, input int page);
    int s = slotOf(PW'(page));
    for (int i = 0; i < PB; i++) begin
      if (op == 0 || op == 4) expBuf[b][i] = expMem[s][i];
      if (op == 2 || op == 3) expMem[s][i] = expBuf[b][i];
    end
  endtask

  function automatic bit expCompare(input bit b, input int page);
    int s = slotOf(PW'(page));
    for (int i = 0; i < PB; i++) if (expMem[s][i] != expBuf[b][i]) return 1'b1;
    return 1'b0;
  endfunction

  task automatic runOp(input int op, input bit b, input int page, input string tag);
    int len = 0;
    wrCount = 0; ffCount = 0;
    issue(op, b, page);
    waitIdle(len);
    applyModel(op, b, page);
    check(len == expDur(op), {tag, " busy length"}, len, expDur(op));
  endtask

  task automatic checkPage(input int page, input string tag);
    int s = slotOf(PW'(page));
    int bad = 0;
    for (int i = 0; i < PB; i++) if (mem[s][i] != expMem[s][i]) bad++;
    check(bad == 0, {tag, " page bytes wrong"}, bad, 0);
  endtask

  task automatic checkBuf(input bit b, input string tag);
    int bad = 0;
    for (int i = 0; i < PB; i++) begin
      hostSel = b; hostAddr = BW'(i);
      #0.1;
      if (hostRdata != expBuf[b][i]) bad++;
    end
    check(bad == 0, {tag, " buffer bytes wrong"}, bad, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < PB; i++) begin
        mem[s][i] = 8'($urandom);
        expMem[s][i] = mem[s][i];
      end
    repeat (3) @(negedge clk);
    check(ready == 1'b1 && rejectBusy == 1'b0 && rejectProtect == 1'b0, "R1 reset flags", ready, 1);
    check(cmpMismatch == 1'b0 && arrWe == 1'b0, "R1 reset status", cmpMismatch, 0);
    rstN = 1'b1;
    @(negedge clk);

    fillBuf(1'b0);
    fillBuf(1'b1);

    // R4 / R13 erase-and-write from buffer 0
    runOp(2, 1'b0, 300, "R4");
    checkPage(300, "R4 R13");
    check(wrCount == 2*PB, "R4 array write count", wrCount, 2*PB);
    check(ffCount >= PB, "R4 erase pass bytes", ffCount, PB);

    // R5 write only from buffer 1
    runOp(3, 1'b1, 301, "R5");
    checkPage(301, "R5 R13");
    check(wrCount == PB, "R5 array write count", wrCount, PB);

    // R2 load page 1000 into buffer 1
    runOp(0, 1'b1, 1000, "R2");
    checkBuf(1'b1, "R2");
    checkPage(1000, "R2 page unchanged");

    // R3 compares
    runOp(1, 1'b1, 1000, "R3 match");
    check(cmpMismatch == 1'b0, "R3 full match", cmpMismatch, 0);
    hostWrite(1'b1, PB-1, expBuf[1][PB-1] ^ 8'h01, 1'b1);
    runOp(1, 1'b1, 1000, "R3 last byte");
    check(cmpMismatch == 1'b1, "R3 single bit differs", cmpMismatch, 1);
    runOp(1, 1'b0, 300, "R3 programmed");
    check(cmpMismatch == expCompare(1'b0, 300), "R3 after program", cmpMismatch, 0);
    runOp(1, 1'b0, 301, "R3 other");
    check(cmpMismatch == expCompare(1'b0, 301), "R3 random differ", cmpMismatch, 1);
    runOp(0, 1'b1, 301, "R3 hold");
    check(cmpMismatch == 1'b1, "R3 status held by load", cmpMismatch, 1);

    // R6 refresh
    runOp(4, 1'b0, 1000, "R6");
    checkPage(1000, "R6");
    checkBuf(1'b0, "R6");
    check(wrCount == 2*PB, "R6 array write count", wrCount, 2*PB);

    // R7 request in the middle of an operation
    begin
      int len = 0;
      issue(2, 1'b0, 300);
      for (int k = 0; k < 10; k++) begin len++; @(negedge clk); end
      reqValid = 1'b1; reqOp = 3'd0; reqBuf = 1'b1; reqPage = PW'(1000);
      @(negedge clk);
      reqValid = 1'b0;
      len++;
      check(rejectBusy == 1'b1, "R7 reject mid operation", rejectBusy, 1);
      waitIdle(len);
      applyModel(2, 1'b0, 300);
      check(len == expDur(2), "R7 duration unchanged", len, expDur(2));
      checkPage(300, "R7");
      checkBuf(1'b1, "R7 refused load");
    end

    // R7 request in the last busy cycle
    begin
      issue(0, 1'b0, 300);
      repeat (PB-1) @(negedge clk);
      check(ready == 1'b0, "R7 last busy cycle", ready, 0);
      reqValid = 1'b1; reqOp = 3'd1; reqBuf = 1'b0; reqPage = PW'(301);
      @(negedge clk);
      reqValid = 1'b0;
      applyModel(0, 1'b0, 300);
      check(rejectBusy == 1'b1 && ready == 1'b1, "R7 last cycle refused", rejectBusy, 1);
      @(negedge clk);
      check(rejectBusy == 1'b0 && ready == 1'b1, "R7 one cycle pulse", ready, 1);
    end

    // R8 write protect
    wpN = 1'b0;
    for (int op = 2; op <= 4; op++) begin
      issue(op, 1'b1, 7);
      check(rejectProtect == 1'b1 && ready == 1'b1, "R8 protected program refused", rejectProtect, 1);
    end
    checkPage(7, "R8 protected page unchanged");
    runOp(0, 1'b1, 7, "R8 load allowed");
    checkBuf(1'b1, "R8");
    runOp(3, 1'b0, 300, "R8 high page allowed");
    checkPage(300, "R8 high page");
    wpN = 1'b1;
    runOp(3, 1'b0, 7, "R8 released");
    checkPage(7, "R8 released");

    // R12 unknown codes
    for (int op = 5; op <= 7; op++) begin
      issue(op, 1'b0, 300);
      check(ready == 1'b1 && rejectProtect == 1'b0 && rejectBusy == 1'b0,
            "R12 unknown code ignored", ready, 1);
    end

    // R10 host writes during operations
    begin
      int len = 0;
      issue(3, 1'b0, 301);
      hostWrite(1'b0, 5, ~expBuf[0][5], 1'b0);
      hostWrite(1'b1, 9, 8'h5A, 1'b1);
      waitIdle(len);
      applyModel(3, 1'b0, 301);
      checkPage(301, "R10 write-only source intact");
      checkBuf(1'b0, "R10 blocked write");
      checkBuf(1'b1, "R10 other buffer write");
      len = 0;
      issue(0, 1'b1, 300);
      hostWrite(1'b0, 3, 8'hC3, 1'b1);
      hostWrite(1'b0, PB-1, 8'h3C, 1'b1);
      waitIdle(len);
      applyModel(0, 1'b1, 300);
      checkBuf(1'b0, "R10 write during load");
      checkBuf(1'b1, "R10 load result");
    end

    // R11 reset abort
    begin
      int len = 0;
      runOp(1, 1'b0, 301, "R11 setup");
      issue(4, 1'b0, 1000);
      repeat (50) @(negedge clk);
      rstN = 1'b0;
      #0.5;
      check(ready == 1'b1 && cmpMismatch == 1'b0, "R11 abort immediate", ready, 1);
      wrCount = 0;
      issue(2, 1'b0, 300);
      check(ready == 1'b1 && wrCount == 0, "R11 idle while held", wrCount, 0);
      @(negedge clk);
      rstN = 1'b1;
      checkPage(1000, "R11 page untouched");
      runOp(0, 1'b0, 1000, "R11 after release");
      checkBuf(1'b0, "R11");
      len = 0;
    end

    // Constrained random operations
    for (int n = 0; n < 8; n++) begin
      int op = $urandom_range(0, 4);
      bit b = 1'($urandom);
      int pg = ($urandom_range(0, 2) == 0) ? 300 : (($urandom_range(0, 1) == 0) ? 301 : 1000);
      if ($urandom_range(0, 2) == 0) hostWrite(b, $urandom_range(0, PB-1), 8'($urandom), 1'b1);
      runOp(op, b, pg, "R9 random");
      checkPage(pg, "R13 random");
      checkBuf(b, "R13 random");
      if (op == 1) check(cmpMismatch == expCompare(b, pg), "R3 random", cmpMismatch, expCompare(b, pg));
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule